// File: doc/BRIEF.md
# Hardware Semaphore Register Bank

This block is a set of independent hardware locks that several bus masters use to take turns on shared resources. Every lock has its own 32-bit word. A master claims a lock by reading that word. If the lock is free, the read returns 1 and the lock becomes taken in the same access, so test-and-set needs no separate write. If the lock is already held, the read returns 0 and nothing changes. The holder frees the lock by writing zero to its word.

For each lock the block also stores the ID of the master that took it. A separate read-only word per lock returns that ID, and 0xFF means the lock is free. The bank has a configurable number of single-cycle slave ports, two by default. When claims for the same free lock arrive on several ports in the same cycle, a fixed-priority choice grants exactly one of them, and the lowest-numbered port wins. Offsets that fall outside both word ranges, and offsets that are not word-aligned, read as zero, ignore writes and raise a one-cycle error pulse.

Top module: `hwsem_bank`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every lock is free, every owner word reads 0xFF, and `bus_rdata` and `bus_err` are zero.
- R2: A read of lock word n at byte offset 0x404 + 4*n (n = 0..29) while lock n is free returns 0x00000001. Lock n becomes taken, and the reading port's `bus_mid` value is recorded as its owner.
- R3: A read of a taken lock word returns 0 and changes neither the taken state nor the owner. This also holds when the reader is the current owner.
- R4: Writing data 0x00000000 to the word of a taken lock frees it, and its owner word then reads 0xFF.
- R5: A write of any nonzero value to a lock word has no effect. A zero write to a lock that is already free also has no effect.
- R6: When two ports read the same free lock in the same cycle, port 0 receives 1 and becomes owner, and port 1 receives 0.
- R7: The owner word of lock n is at byte offset 4*n. It returns the owner ID in bits 7:0 with bits 31:8 zero, or 0xFF when the lock is free. Writes to owner words are ignored.
- R8: An access to an offset outside both ranges, or to an offset with bits 1:0 not zero, reads as 0 and ignores writes. `bus_err` for that port is 1 in the cycle after the strobe and only for that one cycle.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe. In a cycle that follows no read strobe, that port's `bus_rdata` is 0.
- R10: Locks are independent. Claiming or releasing one lock leaves every other lock's state and owner unchanged, and different ports can each claim a different lock in the same cycle.
- R11: If one port reads a taken lock in the same cycle that another port writes zero to it, the read returns 0 and the lock ends up free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd_en | input | N_PORTS | Read strobe, one bit per port |
| bus_wr_en | input | N_PORTS | Write strobe, one bit per port |
| bus_addr | input | N_PORTS*ADDR_W | Byte offset per port, port p in slice p |
| bus_wdata | input | N_PORTS*32 | Write data per port |
| bus_mid | input | N_PORTS*8 | ID of the master driving each port |
| bus_rdata | output | N_PORTS*32 | Registered read data per port |
| bus_err | output | N_PORTS | One-cycle pulse for an access to an unmapped or misaligned offset |

## Verification
Every result is due exactly one clock edge after its strobe. This covers the read data, the error pulse and the change of lock state or owner. The bench applies stimulus 1 ns after an edge, waits for the next rising edge, and samples 1 ns later. Effects that a read cannot show directly, such as an ignored write, a release, or another lock's owner, are checked with a follow-up owner-word read. That read is sampled one edge later in the same way. A further idle cycle confirms that read data and error fall back to zero.

// File: rtl/hwsem_pkg.sv
// hwsem_pkg: shared widths and encodings for the semaphore bank.
// Assumes 32-bit data words and 8-bit master IDs.
package hwsem_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ID_W   = 8;
    localparam logic [ID_W-1:0] ID_FREE = 8'hFF;
endpackage

// File: rtl/hwsem_decode.sv
// hwsem_decode: classifies one port's byte offset as a lock word, an owner
// word or unmapped, and gives the lock index. Purely combinational.
// Assumes both ranges are word aligned and do not overlap.
module hwsem_decode #(
    parameter int unsigned N_LOCKS     = 30,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned LOCK_BASE   = 'h404,
    parameter int unsigned SHADOW_BASE = 'h000,
    localparam int unsigned IDX_W      = $clog2(N_LOCKS),
    localparam int unsigned WW         = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              lock_hit,
    output logic              shd_hit,
    output logic              bad,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [WW-1:0] LK_LO = WW'(LOCK_BASE >> 2);
    localparam logic [WW-1:0] LK_HI = WW'((LOCK_BASE >> 2) + N_LOCKS);
    localparam logic [WW-1:0] SH_LO = WW'(SHADOW_BASE >> 2);
    localparam logic [WW-1:0] SH_HI = WW'((SHADOW_BASE >> 2) + N_LOCKS);

    logic          aligned;
    logic [WW-1:0] word;
    logic [WW-1:0] lk_off;
    logic [WW-1:0] sh_off;

    // Split the offset into a word number and work out the range hits.
    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        word     = addr[ADDR_W-1:2];
        lk_off   = word - LK_LO;
        sh_off   = word - SH_LO;
        lock_hit = aligned && (word >= LK_LO) && (word < LK_HI);
        shd_hit  = aligned && (word >= SH_LO) && (word < SH_HI);
        bad      = !lock_hit && !shd_hit;
        idx      = lock_hit ? lk_off[IDX_W-1:0] : sh_off[IDX_W-1:0];
    end
endmodule

// File: rtl/hwsem_arbiter.sv
// hwsem_arbiter: fixed-priority grant among same-cycle claims on one lock;
// the lowest port number wins. Assumes requests are already qualified by
// the lock being free.
module hwsem_arbiter #(
    parameter int unsigned N_PORTS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req,
    output logic [N_PORTS-1:0] gnt
);
    logic found;

    // Grant the first requesting port, scanning from port 0 upward.
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (req[p] && !found) begin
                gnt[p] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // R6
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R6
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
    // R6
    port0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> gnt[0]);
endmodule

// File: rtl/hwsem_cell.sv
// hwsem_cell: state of one lock, a taken flag and the owner ID.
// Assumes grant is raised only while the lock is free. A grant and a
// release in the same cycle cannot both apply, so the grant is checked first.
module hwsem_cell
    import hwsem_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grant,
    input  logic [ID_W-1:0] grant_id,
    input  logic            release_req,
    output logic            taken,
    output logic [ID_W-1:0] owner
);
    // Update the lock state on a claim or a release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken <= 1'b0;
            owner <= ID_FREE;
        end else if (grant) begin
            taken <= 1'b1;
            owner <= grant_id;
        end else if (release_req && taken) begin
            taken <= 1'b0;
            owner <= ID_FREE;
        end
    end

    // R2
    claim_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (taken && owner == $past(grant_id)));
    // R3
    held_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !release_req) |=> (taken && $stable(owner)));
    // R4
    release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && release_req) |=> !taken);
    // R7
    free_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> owner == ID_FREE);
    // R3
    no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> !grant);
endmodule

// File: rtl/hwsem_bank.sv
// hwsem_bank: multi-port bank of hardware locks. A read of a lock word
// claims the lock, a zero write releases it, and an owner word reports who
// holds it. Assumes the slave ports use single-cycle strobes; all results
// are registered and appear one cycle after the strobe.
module hwsem_bank
    import hwsem_pkg::*;
#(
    parameter int unsigned N_LOCKS     = 30,
    parameter int unsigned N_PORTS     = 2,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned LOCK_BASE   = 'h404,
    parameter int unsigned SHADOW_BASE = 'h000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          bus_rd_en,
    input  logic [N_PORTS-1:0]          bus_wr_en,
    input  logic [N_PORTS*ADDR_W-1:0]   bus_addr,
    input  logic [N_PORTS*DATA_W-1:0]   bus_wdata,
    input  logic [N_PORTS*ID_W-1:0]     bus_mid,
    output logic [N_PORTS*DATA_W-1:0]   bus_rdata,
    output logic [N_PORTS-1:0]          bus_err
);
    localparam int unsigned IDX_W = $clog2(N_LOCKS);

    logic [N_PORTS-1:0] lock_hit;
    logic [N_PORTS-1:0] shd_hit;
    logic [N_PORTS-1:0] bad;
    logic [IDX_W-1:0]   idx [N_PORTS];

    logic [N_PORTS-1:0] gnt [N_LOCKS];
    logic [N_LOCKS-1:0] taken;
    logic [ID_W-1:0]    owner [N_LOCKS];

    logic [DATA_W-1:0]  rdata_q [N_PORTS];
    logic [N_PORTS-1:0] err_q;

    // Address decode, one per port.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_dec
        hwsem_decode #(
            .N_LOCKS(N_LOCKS), .ADDR_W(ADDR_W),
            .LOCK_BASE(LOCK_BASE), .SHADOW_BASE(SHADOW_BASE)
        ) u_dec (
            .addr(bus_addr[p*ADDR_W +: ADDR_W]),
            .lock_hit(lock_hit[p]),
            .shd_hit(shd_hit[p]),
            .bad(bad[p]),
            .idx(idx[p])
        );
    end

    // One arbiter and one state cell per lock.
    for (genvar n = 0; n < N_LOCKS; n++) begin : g_lock
        logic [N_PORTS-1:0] req;
        logic               rel;
        logic [ID_W-1:0]    gid;

        // Gather claims and zero-write releases aimed at this lock.
        always_comb begin
            req = '0;
            rel = 1'b0;
            for (int p = 0; p < N_PORTS; p++) begin
                if (lock_hit[p] && idx[p] == IDX_W'(n)) begin
                    req[p] = bus_rd_en[p] && !taken[n];
                    if (bus_wr_en[p] && bus_wdata[p*DATA_W +: DATA_W] == '0)
                        rel = 1'b1;
                end
            end
        end

        hwsem_arbiter #(.N_PORTS(N_PORTS)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt[n])
        );

        // Pick the master ID of the winning port.
        always_comb begin
            gid = '0;
            for (int p = 0; p < N_PORTS; p++)
                if (gnt[n][p]) gid = bus_mid[p*ID_W +: ID_W];
        end

        hwsem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .grant(|gnt[n]), .grant_id(gid), .release_req(rel),
            .taken(taken[n]), .owner(owner[n])
        );
    end

    // Read data and error register, one per port.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic            won;
        logic [ID_W-1:0] shd_val;

        // Collect this port's claim result and the selected owner ID.
        always_comb begin
            won     = 1'b0;
            shd_val = '0;
            for (int n = 0; n < N_LOCKS; n++) begin
                won = won | gnt[n][p];
                if (idx[p] == IDX_W'(n)) shd_val = owner[n];
            end
        end

        // Register the read result and the error pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata_q[p] <= '0;
                err_q[p]   <= 1'b0;
            end else begin
                err_q[p] <= (bus_rd_en[p] || bus_wr_en[p]) && bad[p];
                if (!bus_rd_en[p])
                    rdata_q[p] <= '0;
                else if (lock_hit[p])
                    rdata_q[p] <= DATA_W'(won);
                else if (shd_hit[p])
                    rdata_q[p] <= DATA_W'(shd_val);
                else
                    rdata_q[p] <= '0;
            end
        end

        assign bus_rdata[p*DATA_W +: DATA_W] = rdata_q[p];
        assign bus_err[p] = err_q[p];

        // R8
        err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_err[p] |-> bus_rdata[p*DATA_W +: DATA_W] == '0);
        // R9
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_rd_en[p] |=> bus_rdata[p*DATA_W +: DATA_W] == '0);
        // R8
        err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_rd_en[p] || bus_wr_en[p]) |=> !bus_err[p]);
    end
endmodule

// File: tb/tb_hwsem_bank.sv
`timescale 1ns/1ps
module tb_hwsem_bank;
    localparam int NP = 2;
    localparam int AW = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    bus_rd_en = '0;
    logic [NP-1:0]    bus_wr_en = '0;
    logic [NP*AW-1:0] bus_addr = '0;
    logic [NP*32-1:0] bus_wdata = '0;
    logic [NP*8-1:0]  bus_mid = '0;
    logic [NP*32-1:0] bus_rdata;
    logic [NP-1:0]    bus_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    hwsem_bank dut (
        .clk(clk), .rst_n(rst_n),
        .bus_rd_en(bus_rd_en), .bus_wr_en(bus_wr_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mid(bus_mid),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    always #2.5 clk = ~clk;

    function automatic logic [11:0] lk(int n);
        return 12'(32'h404 + 4 * n);
    endfunction
    function automatic logic [11:0] sh(int n);
        return 12'(4 * n);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        bus_rd_en = '0;
        bus_wr_en = '0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_mid   = '0;
    endtask

    task automatic set_port(int p, bit rd, bit wr, logic [11:0] a,
                            logic [31:0] d, logic [7:0] m);
        bus_rd_en[p]          = rd;
        bus_wr_en[p]          = wr;
        bus_addr[p*AW +: AW]  = a;
        bus_wdata[p*32 +: 32] = d;
        bus_mid[p*8 +: 8]     = m;
    endtask

    function automatic logic [31:0] rd_of(int p);
        return bus_rdata[p*32 +: 32];
    endfunction

    task automatic do_read(int p, logic [11:0] a, logic [7:0] m,
                           output logic [31:0] d, output logic e);
        idle();
        set_port(p, 1'b1, 1'b0, a, 32'h0, m);
        tick();
        d = rd_of(p);
        e = bus_err[p];
        idle();
    endtask

    task automatic do_write(int p, logic [11:0] a, logic [31:0] v,
                            output logic e);
        idle();
        set_port(p, 1'b0, 1'b1, a, v, 8'h00);
        tick();
        e = bus_err[p];
        idle();
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        chk("R1 rdata after reset", bus_rdata[31:0], 32'h0);
        chk("R1 err after reset", 32'(bus_err), 32'h0);
        do_read(0, sh(0), 8'h01, d, e); chk("R1 owner0 free", d, 32'hFF);
        do_read(1, sh(29), 8'h01, d, e); chk("R1 owner29 free", d, 32'hFF);
    endtask

    task automatic t_claim();
        logic [31:0] d; logic e;
        do_read(0, lk(0), 8'h11, d, e); chk("R2 claim free lock0", d, 32'h1);
        tick(); chk("R9 rdata idle after read", rd_of(0), 32'h0);
        do_read(1, sh(0), 8'h00, d, e); chk("R2 R7 owner recorded", d, 32'h11);
    endtask

    task automatic t_taken();
        logic [31:0] d; logic e;
        do_read(1, lk(0), 8'h22, d, e); chk("R3 other reads taken", d, 32'h0);
        do_read(0, lk(0), 8'h11, d, e); chk("R3 owner rereads", d, 32'h0);
        do_read(0, sh(0), 8'h00, d, e); chk("R3 owner unchanged", d, 32'h11);
    endtask

    task automatic t_ignored();
        logic [31:0] d; logic e;
        do_write(1, lk(0), 32'h5, e);
        do_read(0, sh(0), 8'h00, d, e); chk("R5 nonzero write ignored", d, 32'h11);
        do_write(0, lk(3), 32'h0, e);
        do_read(0, sh(3), 8'h00, d, e); chk("R5 zero write on free lock", d, 32'hFF);
        do_write(0, sh(0), 32'h0, e);
        do_read(1, sh(0), 8'h00, d, e); chk("R7 owner word write ignored", d, 32'h11);
    endtask

    task automatic t_release();
        logic [31:0] d; logic e;
        do_write(0, lk(0), 32'h0, e);
        do_read(0, sh(0), 8'h00, d, e); chk("R4 released owner FF", d, 32'hFF);
        do_read(1, lk(0), 8'h22, d, e); chk("R4 reclaim after release", d, 32'h1);
        do_read(0, sh(0), 8'h00, d, e); chk("R4 new owner", d, 32'h22);
    endtask

    task automatic t_simul();
        logic [31:0] d; logic e;
        idle();
        set_port(0, 1'b1, 1'b0, lk(5), 32'h0, 8'h33);
        set_port(1, 1'b1, 1'b0, lk(5), 32'h0, 8'h44);
        tick();
        chk("R6 port0 wins", rd_of(0), 32'h1);
        chk("R6 port1 loses", rd_of(1), 32'h0);
        idle();
        do_read(1, sh(5), 8'h00, d, e); chk("R6 owner is port0", d, 32'h33);
        set_port(0, 1'b1, 1'b0, lk(6), 32'h0, 8'h55);
        set_port(1, 1'b1, 1'b0, lk(7), 32'h0, 8'h66);
        tick();
        chk("R10 distinct lock p0", rd_of(0), 32'h1);
        chk("R10 distinct lock p1", rd_of(1), 32'h1);
        idle();
        do_read(0, sh(7), 8'h00, d, e); chk("R10 owner7", d, 32'h66);
    endtask

    task automatic t_bounds();
        logic [31:0] d; logic e;
        do_read(0, lk(29), 8'h77, d, e); chk("R2 last lock claim", d, 32'h1);
        chk("R8 no err in range", 32'(e), 32'h0);
        do_read(0, lk(30), 8'h77, d, e);
        chk("R8 past lock range data", d, 32'h0); chk("R8 past lock range err", 32'(e), 32'h1);
        tick(); chk("R8 err one cycle", 32'(bus_err[0]), 32'h0);
        do_read(1, 12'h400, 8'h77, d, e); chk("R8 gap err", 32'(e), 32'h1);
        do_read(1, sh(30), 8'h77, d, e); chk("R8 past owner range err", 32'(e), 32'h1);
        do_read(0, 12'h406, 8'h77, d, e);
        chk("R8 misaligned data", d, 32'h0); chk("R8 misaligned err", 32'(e), 32'h1);
        do_write(1, 12'h47C, 32'h0, e); chk("R8 bad write err", 32'(e), 32'h1);
        do_write(0, 12'h47A, 32'h0, e);
        do_read(0, sh(29), 8'h00, d, e); chk("R8 misaligned write ignored", d, 32'h77);
        do_read(0, sh(28), 8'h00, d, e); chk("R10 neighbour untouched", d, 32'hFF);
        do_read(0, sh(5), 8'h00, d, e); chk("R10 lock5 kept", d, 32'h33);
    endtask

    task automatic t_race();
        logic [31:0] d; logic e;
        idle();
        set_port(0, 1'b1, 1'b0, lk(29), 32'h0, 8'h12);
        set_port(1, 1'b0, 1'b1, lk(29), 32'h0, 8'h00);
        tick();
        chk("R11 claim during release", rd_of(0), 32'h0);
        idle();
        do_read(1, sh(29), 8'h00, d, e); chk("R11 lock ends free", d, 32'hFF);
    endtask

    task automatic t_reset2();
        logic [31:0] d; logic e;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        do_read(0, sh(5), 8'h00, d, e); chk("R1 reset frees held lock", d, 32'hFF);
        do_read(1, lk(0), 8'h09, d, e); chk("R1 claim after reset", d, 32'h1);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_claim();
        t_taken();
        t_ignored();
        t_release();
        t_simul();
        t_bounds();
        t_race();
        t_reset2();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule